// File: doc/BRIEF.md
# Packetized Stream Demultiplexer

This block sits behind an input FIFO and takes a stream of 32-bit words offered with a valid flag. It answers with a full flag when it cannot take a word. The stream carries all device control in-band as packets. A packet opens with a header word, which selects the target memory and the starting address. A length word follows and gives the number of payload words. The payload words come last. The block steers each payload word to one of three memories: the configuration store, the user-data input queue or the register-state store. For each word it drives a write enable on the chosen memory, the word itself and an address that counts up from the header's starting address.

The parser has three states. In `PS_HEADER` it waits for a header; accepting one moves it to `PS_LENGTH`. In `PS_LENGTH`, a zero length sends it back to `PS_HEADER` and any other length moves it to `PS_PAYLOAD`. In `PS_PAYLOAD` it returns to `PS_HEADER` after the last payload word. From `PS_LENGTH` or `PS_PAYLOAD` there is one more exit: if valid stays low for a programmable number of cycles, the parser goes to `PS_HEADER` and raises an error flag. A sink that reports itself full stalls the stream. Payload of the reserved packet kind is accepted and thrown away.

Top module: `pkt_stream_demux`

## Requirements
- R1: After reset, in_full, all three write enables and err are low, and the next accepted word is taken as a header.
- R2: Header bits [1:0] choose the sink: 00 configuration (cfg_we), 01 user data (dat_we), 10 register state (st_we). Each accepted payload word raises that sink's write enable in the same cycle, with wr_data equal to the word.
- R3: wr_addr for the first payload word equals header bits [15:8]. It rises by one for each later payload word and wraps from 255 to 0.
- R4: Bits [15:0] of the length word give the payload word count; bits [31:16] are ignored. After that many payload words, the next word is taken as a header.
- R5: A length of zero ends the packet, and the next word is taken as a header.
- R6: Payload of kind 11 is accepted with in_full low and raises no write enable, whatever the sink full flags say.
- R7: While the selected sink's full input is high during payload, in_full is high, no write enable rises and the word is held. Full flags of the other sinks have no effect.
- R8: Gaps in valid that last fewer than timeout_cycles cycles in the middle of a packet leave the packet intact.
- R9: After timeout_cycles consecutive cycles with valid low in PS_LENGTH or PS_PAYLOAD, err goes high and the parser returns to PS_HEADER. err goes low again after the next header is accepted.
- R10: A timeout_cycles value of 0 disables the timeout.
- R11: An idle stream in PS_HEADER never sets err.
- R12: Header and length words raise no write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Stream word |
| in_valid | input | 1 | Stream word present |
| in_full | output | 1 | Backpressure; the word is not taken |
| timeout_cycles | input | 16 | Idle cycles before a mid-packet abort; 0 disables |
| cfg_full | input | 1 | Configuration store cannot take a write |
| dat_full | input | 1 | User-data queue cannot take a write |
| st_full | input | 1 | State store cannot take a write |
| cfg_we | output | 1 | Write configuration store |
| dat_we | output | 1 | Write user-data queue |
| st_we | output | 1 | Write state store |
| wr_data | output | 32 | Payload word to the selected sink |
| wr_addr | output | 8 | Address in the selected sink |
| err | output | 1 | Mid-packet timeout seen |

## Verification
The assertions assume that in_valid, in_data and the sink full flags are held steady from one edge to the next. They also assume that timeout_cycles changes only while the parser waits for a header. The bench changes every input only at the falling edge. It reprograms the timeout only between packets. The sink full flags it applies are ones a real queue could produce: a flag goes high, the word is held, and the flag later drops.

// File: rtl/pkt_demux_pkg.sv
package pkt_demux_pkg;

    localparam int NSINK = 3;

    typedef enum logic [1:0] {
        PS_HEADER  = 2'd0,
        PS_LENGTH  = 2'd1,
        PS_PAYLOAD = 2'd2
    } parse_state_e;

    typedef enum logic [1:0] {
        PK_CFG   = 2'b00,
        PK_DATA  = 2'b01,
        PK_STATE = 2'b10,
        PK_RSVD  = 2'b11
    } pkt_kind_e;

endpackage

// File: rtl/pkt_idle_timer.sv
module pkt_idle_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mid_pkt,
    input  logic             in_valid,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);

    logic [TMO_W-1:0] idle_q;

    always_comb begin
        expire = mid_pkt && !in_valid && (limit != '0)
                 && (idle_q == limit - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (!mid_pkt || in_valid || expire) begin
            idle_q <= '0;
        end else begin
            idle_q <= idle_q + 1'b1;
        end
    end

    // R8: with a limit above one, an abort always follows an idle cycle
    assert_idle_before_expire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && limit > 1) |-> $past(!in_valid));

    // R10: a zero limit never aborts
    assert_zero_limit_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) |-> !expire);

endmodule

// File: rtl/pkt_sink_route.sv
module pkt_sink_route
    import pkt_demux_pkg::*;
(
    input  logic             payload_act,
    input  logic             in_valid,
    input  pkt_kind_e        kind,
    input  logic [NSINK-1:0] sink_full,
    output logic [NSINK-1:0] sink_we,
    output logic             stall
);

    logic [3:0] full_ext;

    always_comb begin
        full_ext = {1'b0, sink_full};
        stall    = payload_act && full_ext[kind];
    end

    for (genvar g = 0; g < NSINK; g++) begin : g_sink
        always_comb begin
            sink_we[g] = payload_act && in_valid && (kind == pkt_kind_e'(g))
                         && !sink_full[g];
        end
    end

    // R2: at most one sink written per cycle
    always_comb begin
        assert_one_sink_R2: assert ($onehot0(sink_we));
    end

endmodule

// File: rtl/pkt_parse_fsm.sv
module pkt_parse_fsm
    import pkt_demux_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              stall,
    input  logic              expire,
    output parse_state_e      state_q,
    output pkt_kind_e         kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              err_q
);

    localparam int ADDR_LSB = 8;

    parse_state_e      state_n;
    pkt_kind_e         kind_n;
    logic [ADDR_W-1:0] addr_n;
    logic [LEN_W-1:0]  rem_q, rem_n;
    logic              err_n;
    logic              accept;
    logic [LEN_W-1:0]  len_field;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_HEADER;
            kind_q  <= PK_CFG;
            addr_q  <= '0;
            rem_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            kind_q  <= kind_n;
            addr_q  <= addr_n;
            rem_q   <= rem_n;
            err_q   <= err_n;
        end
    end

    always_comb begin
        accept    = in_valid && !stall;
        len_field = in_data[LEN_W-1:0];
        state_n   = state_q;
        kind_n    = kind_q;
        addr_n    = addr_q;
        rem_n     = rem_q;
        err_n     = err_q;
        if (expire) begin
            state_n = PS_HEADER;
            err_n   = 1'b1;
        end else if (accept) begin
            unique case (state_q)
                PS_HEADER: begin
                    kind_n  = pkt_kind_e'(in_data[1:0]);
                    addr_n  = in_data[ADDR_LSB +: ADDR_W];
                    err_n   = 1'b0;
                    state_n = PS_LENGTH;
                end
                PS_LENGTH: begin
                    if (len_field == '0) begin
                        state_n = PS_HEADER;
                    end else begin
                        rem_n   = len_field;
                        state_n = PS_PAYLOAD;
                    end
                end
                PS_PAYLOAD: begin
                    addr_n = addr_q + 1'b1;
                    rem_n  = rem_q - 1'b1;
                    if (rem_q == 1) begin
                        state_n = PS_HEADER;
                    end
                end
                default: state_n = PS_HEADER;
            endcase
        end
    end

    // R5: zero length returns to header
    assert_zero_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_LENGTH && accept && len_field == '0) |=> state_q == PS_HEADER);

    // R4: payload continues until the count runs out
    assert_payload_cont_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PAYLOAD && accept && !expire && rem_q > 1) |=> state_q == PS_PAYLOAD);

    // R3: consecutive payload words use consecutive addresses
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_PAYLOAD && accept && rem_q > 1) |=> addr_q == $past(addr_q) + 1'b1);

    // R9: abort lands in header with the flag raised
    assert_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (state_q == PS_HEADER && err_q));

    // R11: no new error while waiting for a header
    assert_hdr_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_HEADER && !err_q) |=> !err_q);

    // R7: a stalled word leaves the state untouched
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !expire) |=> $stable(state_q) && $stable(addr_q));

endmodule

// File: rtl/pkt_stream_demux.sv
module pkt_stream_demux
    import pkt_demux_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 16,
    parameter int TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_full,
    input  logic [TMO_W-1:0]  timeout_cycles,
    input  logic              cfg_full,
    input  logic              dat_full,
    input  logic              st_full,
    output logic              cfg_we,
    output logic              dat_we,
    output logic              st_we,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              err
);

    parse_state_e     state;
    pkt_kind_e        kind;
    logic [NSINK-1:0] sink_full;
    logic [NSINK-1:0] sink_we;
    logic             stall;
    logic             expire;
    logic             payload_act;
    logic             mid_pkt;

    always_comb begin
        sink_full   = {st_full, dat_full, cfg_full};
        payload_act = (state == PS_PAYLOAD);
        mid_pkt     = (state != PS_HEADER);
    end

    pkt_parse_fsm #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .stall(stall), .expire(expire), .state_q(state), .kind_q(kind),
        .addr_q(wr_addr), .err_q(err)
    );

    pkt_sink_route u_route (
        .payload_act(payload_act), .in_valid(in_valid), .kind(kind),
        .sink_full(sink_full), .sink_we(sink_we), .stall(stall)
    );

    pkt_idle_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .mid_pkt(mid_pkt), .in_valid(in_valid),
        .limit(timeout_cycles), .expire(expire)
    );

    always_comb begin
        in_full = stall;
        cfg_we  = sink_we[0];
        dat_we  = sink_we[1];
        st_we   = sink_we[2];
        wr_data = in_data;
    end

    // R7: backpressure and a write never coincide
    assert_full_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_full |-> !(cfg_we || dat_we || st_we));

    // R12: no write outside payload
    assert_no_write_hdr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PS_PAYLOAD) |-> !(cfg_we || dat_we || st_we));

    // R6: reserved payload never stalls
    assert_rsvd_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (payload_act && kind == PK_RSVD) |-> !in_full);

endmodule

// File: tb/pkt_stream_demux_tb_top.sv
`timescale 1ns/1ps
module pkt_stream_demux_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_full;
    logic [15:0] timeout_cycles = 16'd4;
    logic        cfg_full = 1'b0, dat_full = 1'b0, st_full = 1'b0;
    logic        cfg_we, dat_we, st_we;
    logic [31:0] wr_data;
    logic [7:0]  wr_addr;
    logic        err;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pkt_stream_demux dut_i (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_full(in_full), .timeout_cycles(timeout_cycles),
        .cfg_full(cfg_full), .dat_full(dat_full), .st_full(st_full),
        .cfg_we(cfg_we), .dat_we(dat_we), .st_we(st_we),
        .wr_data(wr_data), .wr_addr(wr_addr), .err(err)
    );

    // row: valid | data | fulls {st,dat,cfg} | exp we {st,dat,cfg} | exp addr | exp full
    localparam int NV = 24;
    localparam logic [47:0] TBL [NV] = '{
        {1'b1, 32'h0000_1000, 3'b000, 3'b000, 8'h00, 1'b0},
        {1'b1, 32'h0000_0003, 3'b000, 3'b000, 8'h00, 1'b0},
        {1'b1, 32'hA000_0001, 3'b000, 3'b001, 8'h10, 1'b0},
        {1'b0, 32'h0000_0000, 3'b000, 3'b000, 8'h00, 1'b0},
        {1'b1, 32'hA000_0002, 3'b000, 3'b001, 8'h11, 1'b0},
        {1'b1, 32'hA000_0003, 3'b001, 3'b000, 8'h00, 1'b1},
        {1'b1, 32'hA000_0003, 3'b110, 3'b001, 8'h12, 1'b0},
        {1'b1, 32'h0000_FF01, 3'b000, 3'b000, 8'h00, 1'b0},
        {1'b1, 32'h0000_0002, 3'b000, 3'b000, 8'h00, 1'b0},
        {1'b1, 32'hB000_0001, 3'b000, 3'b010, 8'hFF, 1'b0},
        {1'b1, 32'hB000_0002, 3'b000, 3'b010, 8'h00, 1'b0},
        {1'b1, 32'h0000_4002, 3'b000, 3'b000, 8'h00, 1'b0},
        {1'b1, 32'hABCD_0000, 3'b000, 3'b000, 8'h00, 1'b0},
        {1'b1, 32'h0000_4002, 3'b000, 3'b000, 8'h00, 1'b0},
        {1'b1, 32'hFFFF_0001, 3'b000, 3'b000, 8'h00, 1'b0},
        {1'b1, 32'hC000_0001, 3'b100, 3'b000, 8'h00, 1'b1},
        {1'b1, 32'hC000_0001, 3'b000, 3'b100, 8'h40, 1'b0},
        {1'b1, 32'h0000_2003, 3'b000, 3'b000, 8'h00, 1'b0},
        {1'b1, 32'h0000_0002, 3'b000, 3'b000, 8'h00, 1'b0},
        {1'b1, 32'hD000_0001, 3'b111, 3'b000, 8'h00, 1'b0},
        {1'b1, 32'hD000_0002, 3'b000, 3'b000, 8'h00, 1'b0},
        {1'b1, 32'h0000_0500, 3'b000, 3'b000, 8'h00, 1'b0},
        {1'b1, 32'h0000_0001, 3'b000, 3'b000, 8'h00, 1'b0},
        {1'b1, 32'hE000_0001, 3'b000, 3'b001, 8'h05, 1'b0}
    };

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] d, input logic [2:0] f);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        {st_full, dat_full, cfg_full} = f;
        #1;
    endtask

    function automatic logic [2:0] we_vec();
        return {st_we, dat_we, cfg_we};
    endfunction

    task automatic expect_write(input string tag, input logic [2:0] we,
                                input logic [7:0] addr);
        chk(we_vec() == we, tag, we_vec(), we);
        if (we != 3'b000) begin
            chk(wr_addr == addr, tag, wr_addr, addr);
            chk(wr_data == in_data, tag, wr_data, in_data);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(!in_full, "R1 in_full", in_full, 0);
        chk(we_vec() == 3'b000, "R1 we", we_vec(), 0);
        chk(!err, "R1 err", err, 0);

        // table walk: R2 R3 R4 R5 R6 R7 R12
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i][47], TBL[i][46:15], TBL[i][14:12]);
            chk(in_full == TBL[i][0], $sformatf("R7/R6 full row %0d", i), in_full, TBL[i][0]);
            expect_write($sformatf("R2/R3/R4/R5/R12 row %0d", i), TBL[i][11:9], TBL[i][8:1]);
        end

        // R8: short gap mid-packet survives
        drive(1'b1, 32'h0000_3001, 3'b000);
        drive(1'b1, 32'h0000_0003, 3'b000);
        drive(1'b1, 32'h1111_0000, 3'b000);
        expect_write("R2 dat first", 3'b010, 8'h30);
        for (int i = 0; i < 3; i++) drive(1'b0, 32'h0, 3'b000);
        drive(1'b1, 32'h1111_0001, 3'b000);
        expect_write("R8 after gap", 3'b010, 8'h31);
        chk(!err, "R8 err", err, 0);

        // R9: long gap aborts
        for (int i = 0; i < 4; i++) drive(1'b0, 32'h0, 3'b000);
        drive(1'b1, 32'h0000_2201, 3'b000);
        chk(err, "R9 err set", err, 1);
        expect_write("R9 resync header", 3'b000, 8'h00);
        drive(1'b1, 32'h0000_0001, 3'b000);
        chk(!err, "R9 err cleared", err, 0);
        drive(1'b1, 32'h2222_0000, 3'b000);
        expect_write("R9 new packet", 3'b010, 8'h22);

        // R11: idle in header
        for (int i = 0; i < 10; i++) drive(1'b0, 32'h0, 3'b000);
        chk(!err, "R11 idle header", err, 0);

        // R10: timeout disabled
        @(negedge clk);
        timeout_cycles = 16'd0;
        drive(1'b1, 32'h0000_0700, 3'b000);
        drive(1'b1, 32'h0000_0002, 3'b000);
        drive(1'b1, 32'h3333_0000, 3'b000);
        expect_write("R10 first", 3'b001, 8'h07);
        for (int i = 0; i < 20; i++) drive(1'b0, 32'h0, 3'b000);
        chk(!err, "R10 err", err, 0);
        drive(1'b1, 32'h3333_0001, 3'b000);
        expect_write("R10 resumes", 3'b001, 8'h08);

        drive(1'b0, 32'h0, 3'b000);
        summary();
    end

endmodule